// File: doc/BRIEF.md
# MDIO Management Master

This block lets a CPU read and write registers in an external Ethernet PHY over the two-wire management bus. It derives the management clock (MDC) from the system clock. It serialises Clause 22 frames on MDIO, and for reads it shifts in the data the PHY returns. Software reaches it through six small registers, selected by a 3-bit index.

A write begins when software stores the 16-bit value in the write-data register. A read begins when software sets the read bit in the command register. Software polls the status register for busy and, on reads, for not-valid, then collects the result. It clears the read bit before issuing the next read. A management-reset bit in the configuration register forces the engine and its flags back to idle and holds them there until the bit is cleared.

Top module: `mdio_master`

## Requirements
- R1: After `rst_ni` the configuration register reads 0x0003 (divide by 40). The status register, read-data register and command register read 0. `mdc_o` and `mdio_oe_o` are low.
- R2: The clock-select field (configuration bits 1:0) sets the MDC period to 4, 10, 20 or 40 system clocks for values 0, 1, 2 and 3. MDC is low whenever no frame is active.
- R3: A register write to index 3 while idle stores the value and sends a 64-bit frame, most significant bit first. The frame is 32 ones, `01`, opcode `01`, the PHY address (address register bits 12:8), the register address (bits 4:0), `10`, then the 16 data bits. `mdio_o` changes only when MDC falls.
- R4: A register write to index 1 that changes bit 0 from 0 to 1 while idle sends a read frame with opcode `10`. `mdio_oe_o` is low for the last 18 bit times (turnaround and data). Writing bit 0 back to 0 starts nothing.
- R5: During a read the block samples `mdio_i` on each of the 16 data-bit rising MDC edges, most significant bit first. The result appears in the read-data register (index 4).
- R6: Status bit 0 (busy) is high from the clock after the starting register write for exactly 64 MDC periods. It falls on the last falling MDC edge.
- R7: Status bit 1 (not-valid) is set when a read starts and falls in the same cycle as busy when the read completes. It is never high while busy is low.
- R8: While busy, a write to index 3 leaves the write-data register unchanged and starts nothing. A read-bit write also starts nothing.
- R9: The read-data register changes only when a read frame completes. Write frames and management resets leave it as it was.
- R10: Setting configuration bit 15 drops busy, not-valid, MDC and the output enable by the second clock after the register write. While the bit stays set, no command starts.
- R11: Register indexes are 0 configuration, 1 command, 2 address, 3 write data, 4 read data (read-only), 5 status. Reads return the stored fields at the positions stated above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register index |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for the selected index |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Drive enable for the MDIO line |
| mdio_i | input | 1 | Management data sampled from the line |

## Verification
The assertions rely on three things. Register writes reach the block only on `reg_we_i`. The clock-select field is not changed while a frame is active. `mdio_i` follows the output whenever the output enable is high. The bench keeps to this in three ways. It changes the clock select only between frames, while busy is low. It resolves the line as the driven value when enabled and as the responder's value or a pull-up otherwise. It issues every register write on a falling clock edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [2:0] {
    RA_CFG   = 3'd0,
    RA_CMD   = 3'd1,
    RA_ADDR  = 3'd2,
    RA_WDATA = 3'd3,
    RA_RDATA = 3'd4,
    RA_STAT  = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    OP_WR = 2'b01,
    OP_RD = 2'b10
  } mdio_op_e;

  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] TA_WR     = 2'b10;

  // half MDC period in system clocks per clock-select value
  function automatic int unsigned half_period(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2;
      2'd1:    return 5;
      2'd2:    return 10;
      default: return 20;
    endcase
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  output logic       mdc_o,
  output logic       rise_o,
  output logic       fall_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic [CNT_W-1:0] lim;
  logic             wrap;

  assign lim    = CNT_W'(half_period(sel_i) - 1);
  assign wrap   = run_i && (cnt_q == lim);
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned PHY_AW  = 5,
  parameter int unsigned REG_AW  = 5,
  parameter int unsigned PRE_LEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mgmt_rst_i,
  input  logic              start_wr_i,
  input  logic              start_rd_i,
  input  logic [PHY_AW-1:0] phy_i,
  input  logic [REG_AW-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              done_rd_o,
  output logic [DATA_W-1:0] cap_o
);
  localparam int unsigned FRAME_W  = PRE_LEN + 4 + PHY_AW + REG_AW + 2 + DATA_W;
  localparam int unsigned TA_POS   = PRE_LEN + 4 + PHY_AW + REG_AW;
  localparam int unsigned DATA_POS = TA_POS + 2;
  localparam int unsigned IDX_W    = $clog2(FRAME_W);

  logic [FRAME_W-1:0] shift_q;
  logic [IDX_W-1:0]   idx_q;
  logic               busy_q;
  logic               rd_q;
  logic [DATA_W-1:0]  cap_q;
  logic               last;
  logic               start;
  mdio_op_e           op;

  assign last  = idx_q == IDX_W'(FRAME_W - 1);
  assign start = (start_wr_i || start_rd_i) && !busy_q;
  assign op    = start_rd_i ? OP_RD : OP_WR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      cap_q   <= '0;
    end else if (mgmt_rst_i) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
    end else if (start) begin
      busy_q  <= 1'b1;
      rd_q    <= start_rd_i;
      idx_q   <= '0;
      shift_q <= {{PRE_LEN{1'b1}}, START_PAT, op, phy_i, reg_i,
                  (start_rd_i ? 2'b00 : TA_WR),
                  (start_rd_i ? {DATA_W{1'b0}} : wdata_i)};
    end else if (busy_q) begin
      if (rise_i && rd_q && (idx_q >= IDX_W'(DATA_POS)))
        cap_q <= {cap_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (last) begin
          busy_q <= 1'b0;
        end else begin
          idx_q   <= idx_q + 1'b1;
          shift_q <= {shift_q[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign mdio_o    = busy_q && shift_q[FRAME_W-1];
  assign mdio_oe_o = busy_q && !(rd_q && (idx_q >= IDX_W'(TA_POS)));
  assign done_rd_o = busy_q && rd_q && fall_i && last;
  assign cap_o     = cap_q;
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PHY_AW    = 5,
  parameter int unsigned REG_AW    = 5,
  parameter int unsigned PHY_SHIFT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              done_rd_i,
  input  logic [DATA_W-1:0] cap_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mgmt_rst_o,
  output logic [1:0]        clk_sel_o,
  output logic              start_wr_o,
  output logic              start_rd_o,
  output logic [PHY_AW-1:0] phy_o,
  output logic [REG_AW-1:0] reg_o,
  output logic              not_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned RST_BIT = DATA_W - 1;

  logic              cfg_rst_q;
  logic [1:0]        clk_sel_q;
  logic              cmd_rd_q;
  logic [PHY_AW-1:0] phy_q;
  logic [REG_AW-1:0] reg_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              nv_q;
  logic              idle;

  assign idle       = !busy_i && !cfg_rst_q;
  assign start_wr_o = we_i && (sel_i == RA_WDATA) && idle;
  assign start_rd_o = we_i && (sel_i == RA_CMD) && wdata_i[0] && !cmd_rd_q && idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_rst_q <= 1'b0;
      clk_sel_q <= 2'b11;
      cmd_rd_q  <= 1'b0;
      phy_q     <= '0;
      reg_q     <= '0;
      wdata_q   <= '0;
      rd_data_q <= '0;
      nv_q      <= 1'b0;
    end else begin
      if (we_i && (sel_i == RA_CFG)) begin
        cfg_rst_q <= wdata_i[RST_BIT];
        clk_sel_q <= wdata_i[1:0];
      end
      if (we_i && (sel_i == RA_CMD)) cmd_rd_q <= wdata_i[0];
      if (we_i && (sel_i == RA_ADDR)) begin
        phy_q <= wdata_i[PHY_SHIFT +: PHY_AW];
        reg_q <= wdata_i[REG_AW-1:0];
      end
      if (start_wr_o) wdata_q <= wdata_i;
      if (done_rd_i) rd_data_q <= cap_i;
      if (cfg_rst_q)       nv_q <= 1'b0;
      else if (start_rd_o) nv_q <= 1'b1;
      else if (done_rd_i)  nv_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel_i)
      RA_CFG: begin
        rdata_o[RST_BIT] = cfg_rst_q;
        rdata_o[1:0]     = clk_sel_q;
      end
      RA_CMD:   rdata_o[0] = cmd_rd_q;
      RA_ADDR: begin
        rdata_o[PHY_SHIFT +: PHY_AW] = phy_q;
        rdata_o[REG_AW-1:0]          = reg_q;
      end
      RA_WDATA: rdata_o = wdata_q;
      RA_RDATA: rdata_o = rd_data_q;
      RA_STAT: begin
        rdata_o[0] = busy_i;
        rdata_o[1] = nv_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign mgmt_rst_o  = cfg_rst_q;
  assign clk_sel_o   = clk_sel_q;
  assign phy_o       = phy_q;
  assign reg_o       = reg_q;
  assign not_valid_o = nv_q;
  assign rd_data_o   = rd_data_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PHY_AW    = 5,
  parameter int unsigned REG_AW    = 5,
  parameter int unsigned PRE_LEN   = 32,
  parameter int unsigned PHY_SHIFT = 8,
  parameter int unsigned CNT_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic              busy;
  logic              not_valid;
  logic              mgmt_rst;
  logic [1:0]        clk_sel;
  logic              start_wr;
  logic              start_rd;
  logic [PHY_AW-1:0] phy;
  logic [REG_AW-1:0] regad;
  logic              done_rd;
  logic [DATA_W-1:0] cap;
  logic [DATA_W-1:0] rd_data;
  logic              rise;
  logic              fall;

  mdio_regs #(
    .DATA_W(DATA_W), .PHY_AW(PHY_AW), .REG_AW(REG_AW), .PHY_SHIFT(PHY_SHIFT)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .busy_i     (busy),
    .done_rd_i  (done_rd),
    .cap_i      (cap),
    .rdata_o    (reg_rdata_o),
    .mgmt_rst_o (mgmt_rst),
    .clk_sel_o  (clk_sel),
    .start_wr_o (start_wr),
    .start_rd_o (start_rd),
    .phy_o      (phy),
    .reg_o      (regad),
    .not_valid_o(not_valid),
    .rd_data_o  (rd_data)
  );

  mdio_clkgen #(.CNT_W(CNT_W)) u_clkgen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy && !mgmt_rst),
    .sel_i (clk_sel),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  mdio_frame #(
    .DATA_W(DATA_W), .PHY_AW(PHY_AW), .REG_AW(REG_AW), .PRE_LEN(PRE_LEN)
  ) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mgmt_rst_i(mgmt_rst),
    .start_wr_i(start_wr),
    .start_rd_i(start_rd),
    .phy_i     (phy),
    .reg_i     (regad),
    .wdata_i   (reg_wdata_i),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .done_rd_o (done_rd),
    .cap_o     (cap)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic              mdc_o,
  input logic              mdio_o,
  input logic              mdio_oe_o,
  input logic              busy,
  input logic              not_valid,
  input logic              mgmt_rst,
  input logic [DATA_W-1:0] rd_data
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!mdc_o && !mdio_oe_o)) else $error("line active while idle"); // R2

  AST_MDIO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy) && mdio_oe_o && !$stable(mdio_o)) |-> $fell(mdc_o))
    else $error("mdio changed off falling mdc"); // R3

  AST_BUSY_FROM_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(reg_we_i)) else $error("busy rose without write"); // R6

  AST_NV_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    not_valid |-> busy) else $error("not-valid without busy"); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd_data) |-> $fell(busy)) else $error("read data changed mid-frame"); // R9

  AST_MGMT_RST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_rst |=> (!busy && !not_valid && !mdc_o)) else $error("reset did not idle"); // R10
endmodule

bind mdio_master mdio_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .reg_we_i (reg_we_i),
  .mdc_o    (mdc_o),
  .mdio_o   (mdio_o),
  .mdio_oe_o(mdio_oe_o),
  .busy     (busy),
  .not_valid(not_valid),
  .mgmt_rst (mgmt_rst),
  .rd_data  (rd_data)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  localparam logic [4:0] PHY_ID = 5'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  sel = '0;
  logic [15:0] wd = '0;
  logic [15:0] rd;
  logic        mdc, mdo, moe, mdi;

  always #5 clk = ~clk;

  mdio_master uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .mdc_o(mdc), .mdio_o(mdo),
    .mdio_oe_o(moe), .mdio_i(mdi)
  );

  // behavioural PHY responder
  logic [15:0] phy_mem [32];
  logic [63:0] rx_frame = '0;
  int          rx_cnt = 0;
  int          frames = 0;
  logic        rd_sel = 1'b0;
  logic [15:0] rd_word = '0;
  longint      last_rise = -1;
  longint      mdc_per = 0;

  assign mdi = moe ? mdo :
               ((rd_sel && rx_cnt >= 48 && rx_cnt <= 63) ? rd_word[63-rx_cnt] : 1'b1);

  initial for (int i = 0; i < 32; i++) phy_mem[i] = '0;

  always @(posedge moe) begin
    rx_cnt = 0;
    rd_sel = 1'b0;
    last_rise = -1;
  end

  always @(posedge mdc) begin
    if (last_rise >= 0) mdc_per = ($time - last_rise) / 10;
    last_rise = $time;
    rx_frame = {rx_frame[62:0], mdi};
    rx_cnt++;
    if (rx_cnt == 46 && rx_frame[11:10] == 2'b10 && rx_frame[9:5] == PHY_ID) begin
      rd_sel  = 1'b1;
      rd_word = phy_mem[rx_frame[4:0]];
    end
    if (rx_cnt == 64) begin
      frames++;
      if (rx_frame[29:28] == 2'b01 && rx_frame[27:23] == PHY_ID)
        phy_mem[rx_frame[22:18]] = rx_frame[15:0];
    end
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int r);
    return 16'(r * 16'h0841) ^ 16'hA5C3;
  endfunction

  function automatic logic [63:0] frm(input logic [1:0] op, input logic [4:0] p,
                                      input logic [4:0] r, input logic [1:0] ta,
                                      input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, op, p, r, ta, d};
  endfunction

  function automatic logic [15:0] adr(input logic [4:0] p, input logic [4:0] r);
    return {3'b000, p, 3'b000, r};
  endfunction

  task automatic bus_wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] s, output logic [15:0] v);
    sel = s;
    #1;
    v = rd;
  endtask

  task automatic wait_idle(output int bc, output int ol);
    bc = 0; ol = 0;
    while (1) begin
      sel = 3'd5;
      #1;
      if (!rd[0]) break;
      bc++;
      if (!moe) ol++;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int bc, ol, f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    bus_rd(3'd0, v); chk("R1 cfg reset", v, 16'h0003);
    bus_rd(3'd5, v); chk("R1 status reset", v, 0);
    bus_rd(3'd4, v); chk("R1 rdata reset", v, 0);
    bus_rd(3'd1, v); chk("R1 cmd reset", v, 0);
    chk("R1 mdc low", mdc, 0);
    chk("R1 oe low", moe, 0);

    // clock-select sweep: period, busy span, frame
    for (int s = 0; s < 4; s++) begin
      int dv;
      dv = (s == 0) ? 4 : (s == 1) ? 10 : (s == 2) ? 20 : 40;
      bus_wr(3'd0, 16'(s));
      bus_wr(3'd2, adr(PHY_ID, 5'(s + 1)));
      bus_wr(3'd3, pat(s + 40));
      wait_idle(bc, ol);
      chk("R2 mdc period", mdc_per, dv);
      chk("R6 busy span", bc, 64 * dv);
      chk("R3 write frame", rx_frame, frm(2'b01, PHY_ID, 5'(s + 1), 2'b10, pat(s + 40)));
      chk("R2 mdc idle low", mdc, 0);
    end
    bus_rd(3'd2, v); chk("R11 addr readback", v, adr(PHY_ID, 5'd4));
    bus_rd(3'd3, v); chk("R11 wdata readback", v, pat(43));

    bus_wr(3'd0, 16'h0000);
    for (int r = 0; r < 32; r++) begin
      bus_wr(3'd2, adr(PHY_ID, 5'(r)));
      bus_wr(3'd3, pat(r));
      wait_idle(bc, ol);
      chk("R3 write sweep", rx_frame, frm(2'b01, PHY_ID, 5'(r), 2'b10, pat(r)));
    end

    for (int r = 0; r < 32; r++) begin
      bus_wr(3'd2, adr(PHY_ID, 5'(r)));
      f0 = frames;
      bus_wr(3'd1, 16'h0001);
      bus_rd(3'd5, v); chk("R7 busy and not-valid", v, 3);
      wait_idle(bc, ol);
      chk("R4 line released", ol, 18 * 4);
      bus_rd(3'd5, v); chk("R7 flags clear", v, 0);
      bus_rd(3'd4, v); chk("R5 read data", v, pat(r));
      chk("R4 read frame", rx_frame, frm(2'b10, PHY_ID, 5'(r), 2'b11, pat(r)));
      bus_wr(3'd1, 16'h0000);
      idle(20);
      chk("R4 clear starts nothing", frames, f0 + 1);
    end

    bus_wr(3'd2, adr(5'd7, 5'd3));
    bus_wr(3'd1, 16'h0001);
    wait_idle(bc, ol);
    bus_rd(3'd4, v); chk("R5 absent phy", v, 16'hFFFF);
    bus_wr(3'd1, 16'h0000);

    // commands while busy
    f0 = frames;
    bus_wr(3'd2, adr(PHY_ID, 5'd9));
    bus_wr(3'd3, 16'h1234);
    bus_wr(3'd3, 16'hBEEF);
    bus_rd(3'd3, v); chk("R8 wdata kept", v, 16'h1234);
    bus_wr(3'd1, 16'h0001);
    bus_rd(3'd5, v); chk("R8 read not started", v, 1);
    wait_idle(bc, ol);
    idle(30);
    chk("R8 single frame", frames, f0 + 1);
    chk("R8 frame data", rx_frame[15:0], 16'h1234);
    bus_rd(3'd5, v); chk("R8 idle after", v, 0);
    bus_wr(3'd1, 16'h0000);
    bus_rd(3'd4, v); chk("R9 rdata after write", v, 16'hFFFF);

    // management reset mid-read
    bus_wr(3'd2, adr(PHY_ID, 5'd2));
    bus_wr(3'd1, 16'h0001);
    idle(50);
    bus_wr(3'd0, 16'h8000);
    @(negedge clk);
    bus_rd(3'd5, v); chk("R10 flags idle", v, 0);
    chk("R10 mdc low", mdc, 0);
    chk("R10 oe low", moe, 0);
    bus_wr(3'd1, 16'h0000);
    f0 = frames;
    bus_wr(3'd3, 16'h5555);
    bus_wr(3'd1, 16'h0001);
    idle(10);
    bus_rd(3'd5, v); chk("R10 no start in reset", v, 0);
    chk("R10 no frame in reset", frames, f0);
    bus_rd(3'd0, v); chk("R11 cfg readback", v, 16'h8000);
    bus_wr(3'd1, 16'h0000);
    bus_wr(3'd0, 16'h0000);
    bus_rd(3'd4, v); chk("R9 rdata after abort", v, 16'hFFFF);

    bus_wr(3'd2, adr(PHY_ID, 5'd5));
    bus_wr(3'd1, 16'h0001);
    wait_idle(bc, ol);
    bus_rd(3'd4, v); chk("R5 read after reset", v, pat(5));
    bus_wr(3'd1, 16'h0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule